// File: doc/BRIEF.md
# Command and Response Queue Threshold Interrupts

This block sits in a programmed-I/O host controller between the software-facing queue windows and the transfer engine. It holds a command queue and a response queue, both 32 bits wide. The command queue is 16 entries deep and the response queue is 8 entries deep. Each queue keeps its own occupancy counter. The block turns the two fill levels into two level interrupts. The command-ready interrupt tells software that there is room to post more commands. The response-ready interrupt tells software that enough responses are waiting to be read.

Each interrupt has an 8-bit threshold register, loaded through a one-cycle write port. The two thresholds are encoded differently:

- **Response threshold:** a fill count offset by one. A value of N means "at least N+1 words present".
- **Command threshold:** a count of free slots. A value of N means "at least N free slots", except that 0 means "queue completely empty".

Values written above the legal range are clamped to the range maximum. Both interrupts are recomputed combinationally from the registered occupancy and the registered thresholds. An interrupt therefore drops in the same cycle that its condition stops holding. Illegal pushes and pops are discarded and recorded in sticky per-queue flags.

Top module: `qthr_irq_top`

## Requirements
- R1: Out of reset, both occupancy counts are 0, all four sticky flags are 0, and both threshold registers read 1. As a result, the command-ready interrupt is high and the response-ready interrupt is low.
- R2: The command queue holds up to 16 words and returns them in push order. The head word is visible on `cmd_rdata` whenever `cmd_count` is non-zero, and a pop removes it at the next clock edge.
- R3: The response queue holds up to 8 words and returns them in push order, with the same head visibility and pop timing as the command queue.
- R4: Overflow and underflow handling:
  - A push to a full queue is discarded, leaving both count and contents unchanged, and sets that queue's sticky overflow flag.
  - A pop from an empty queue is discarded and sets that queue's sticky underflow flag.
  - These flags clear only on reset.
- R5: When push and pop are both asserted in the same cycle:
  - If the queue is neither full nor empty, both are performed and the count is unchanged.
  - If the queue is full, only the pop is performed and overflow is flagged.
  - If the queue is empty, only the push is performed and underflow is flagged.
- R6: With response threshold N, `rsp_ready_irq` is high exactly when `rsp_count` >= N+1. It follows the count in the same cycle as the count changes.
- R7: With command threshold 0, `cmd_ready_irq` is high exactly when `cmd_count` is 0.
- R8: With command threshold N from 1 to 15, `cmd_ready_irq` is high exactly when 16 - `cmd_count` >= N. It follows the count in the same cycle as the count changes.
- R9: Threshold writes:
  - A write with `thr_wr` high loads the command threshold when `thr_sel` is 0 and the response threshold when `thr_sel` is 1.
  - The new value is visible on `cmd_thr`/`rsp_thr` and takes effect on the interrupts after the next clock edge.
  - Values above 15 (command) or 7 (response) are stored as 15 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_push | input | 1 | Push `cmd_wdata` into the command queue |
| cmd_wdata | input | 32 | Command word to push |
| cmd_pop | input | 1 | Remove the command queue head |
| cmd_rdata | output | 32 | Command queue head word |
| cmd_count | output | 5 | Command queue occupancy |
| cmd_ovf | output | 1 | Sticky command overflow flag |
| cmd_udf | output | 1 | Sticky command underflow flag |
| rsp_push | input | 1 | Push `rsp_wdata` into the response queue |
| rsp_wdata | input | 32 | Response word to push |
| rsp_pop | input | 1 | Remove the response queue head |
| rsp_rdata | output | 32 | Response queue head word |
| rsp_count | output | 4 | Response queue occupancy |
| rsp_ovf | output | 1 | Sticky response overflow flag |
| rsp_udf | output | 1 | Sticky response underflow flag |
| thr_wr | input | 1 | Threshold write strobe |
| thr_sel | input | 1 | 0 selects the command threshold, 1 the response threshold |
| thr_wdata | input | 8 | Threshold value to write |
| cmd_thr | output | 8 | Current command threshold |
| rsp_thr | output | 8 | Current response threshold |
| cmd_ready_irq | output | 1 | Command-ready level interrupt |
| rsp_ready_irq | output | 1 | Response-ready level interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 16-deep command queue, an 8-deep response queue and 8-bit thresholds. These depths are small enough that random pushes and pops drive both queues to full and to empty many times. Every threshold value, including the command value 0 and out-of-range writes, is therefore compared against every occupancy level. With these sizes the full-and-empty corners of simultaneous push and pop can also be reached directly, so the discard rules and sticky flags are exercised as well as the normal interrupt edges.

// File: rtl/qthr_pkg.sv
// Package: shared definitions for the queue threshold interrupt block.
// Assumes: included before every other file of the block.
package qthr_pkg;

    // Threshold encoding variants used by qthr_level.
    typedef enum logic {
        THR_FREE_SLOTS    = 1'b0,  // 0 = queue empty, N = at least N free slots
        THR_FILL_PLUS_ONE = 1'b1   // N = at least N+1 filled entries
    } thr_mode_e;

    // Reset value of every threshold register.
    localparam int THR_RESET = 1;

endpackage

// File: rtl/qthr_fifo.sv
// Module: qthr_fifo
// What: a first-word-fall-through queue with an occupancy counter. Illegal
//       pushes (when full) and pops (when empty) are dropped and recorded in
//       sticky flags that only reset clears.
// Assumes: DEPTH >= 2. A push and a pop in the same cycle are judged against
//          the occupancy seen before that clock edge.
module qthr_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              udf
);

    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              full;
    logic              empty;
    logic              do_push;
    logic              do_pop;

    // Accept/reject decisions from the pre-edge occupancy.
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Storage write; contents need no reset because the count guards reads.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Head word is presented without a pop request.
    assign rdata = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Sticky error flags; cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            if (push && full) begin
                ovf <= 1'b1;
            end
            if (pop && empty) begin
                udf <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);                                            // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);                                                  // R4
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        udf |=> udf);                                                  // R4
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == FULL_CNT) |=> ($stable(count) && ovf)); // R4
    AST_EMPTY_POP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0 && udf));        // R4
    AST_PUSH_POP_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && count != '0 && count != FULL_CNT) |=> $stable(count)); // R5

endmodule

// File: rtl/qthr_level.sv
// Module: qthr_level
// What: one threshold register with clamp-on-write, and the comparison that
//       turns a queue occupancy into a level interrupt. MODE selects how the
//       threshold value is read (free-slot count or fill count offset by one).
// Assumes: count never exceeds DEPTH; THR_MAX fits in THR_W bits.
module qthr_level
    import qthr_pkg::*;
#(
    parameter thr_mode_e MODE    = THR_FREE_SLOTS,
    parameter int        DEPTH   = 16,
    parameter int        THR_W   = 8,
    parameter int        THR_MAX = 15,
    localparam int       CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [THR_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    output logic [THR_W-1:0] thr_q,
    output logic             irq
);

    localparam logic [THR_W-1:0] MAX_VAL = THR_W'(THR_MAX);
    localparam logic [THR_W-1:0] RST_VAL = THR_W'(THR_RESET);

    logic [31:0] cnt32;
    logic [31:0] thr32;

    // Threshold register; out-of-range writes are clamped to the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= RST_VAL;
        end else if (we) begin
            thr_q <= (wdata > MAX_VAL) ? MAX_VAL : wdata;
        end
    end

    // Widen both operands so the comparison cannot wrap.
    always_comb begin
        cnt32 = 32'(count);
        thr32 = 32'(thr_q);
    end

    generate
        if (MODE == THR_FREE_SLOTS) begin : g_free
            // Free-slot rule: 0 means completely empty, otherwise >= N free.
            always_comb begin
                if (thr32 == 32'd0) begin
                    irq = (cnt32 == 32'd0);
                end else begin
                    irq = ((32'(DEPTH) - cnt32) >= thr32);
                end
            end

            AST_ZERO_THR_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                (thr_q == '0 && count != '0) |-> !irq);                // R7
        end else begin : g_fill
            // Fill rule: at least N+1 entries present.
            always_comb begin
                irq = (cnt32 >= thr32 + 32'd1);
            end

            AST_EMPTY_NO_FILL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
                (count == '0) |-> !irq);                               // R6
        end
    endgenerate

    AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        thr_q <= MAX_VAL);                                             // R9
    AST_THR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(thr_q));                                       // R9

endmodule

// File: rtl/qthr_irq_top.sv
// Module: qthr_irq_top
// What: command and response queues with their threshold registers and the
//       two level interrupts derived from the queue occupancies.
// Assumes: the threshold write port carries one write per cycle at most;
//          interrupt enable and masking live outside this block.
module qthr_irq_top
    import qthr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CMD_DEPTH = 16,
    parameter int RSP_DEPTH = 8,
    parameter int THR_W     = 8,
    localparam int CMD_CNT_W = $clog2(CMD_DEPTH + 1),
    localparam int RSP_CNT_W = $clog2(RSP_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_push,
    input  logic [DATA_W-1:0]    cmd_wdata,
    input  logic                 cmd_pop,
    output logic [DATA_W-1:0]    cmd_rdata,
    output logic [CMD_CNT_W-1:0] cmd_count,
    output logic                 cmd_ovf,
    output logic                 cmd_udf,
    input  logic                 rsp_push,
    input  logic [DATA_W-1:0]    rsp_wdata,
    input  logic                 rsp_pop,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [RSP_CNT_W-1:0] rsp_count,
    output logic                 rsp_ovf,
    output logic                 rsp_udf,
    input  logic                 thr_wr,
    input  logic                 thr_sel,
    input  logic [THR_W-1:0]     thr_wdata,
    output logic [THR_W-1:0]     cmd_thr,
    output logic [THR_W-1:0]     rsp_thr,
    output logic                 cmd_ready_irq,
    output logic                 rsp_ready_irq
);

    localparam int CMD_THR_MAX = CMD_DEPTH - 1;
    localparam int RSP_THR_MAX = RSP_DEPTH - 1;

    logic cmd_thr_we;
    logic rsp_thr_we;

    // Steer the shared threshold write port to one register.
    always_comb begin
        cmd_thr_we = thr_wr && !thr_sel;
        rsp_thr_we = thr_wr && thr_sel;
    end

    qthr_fifo #(.DATA_W(DATA_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_push),
        .wdata (cmd_wdata),
        .pop   (cmd_pop),
        .rdata (cmd_rdata),
        .count (cmd_count),
        .ovf   (cmd_ovf),
        .udf   (cmd_udf)
    );

    qthr_fifo #(.DATA_W(DATA_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rsp_push),
        .wdata (rsp_wdata),
        .pop   (rsp_pop),
        .rdata (rsp_rdata),
        .count (rsp_count),
        .ovf   (rsp_ovf),
        .udf   (rsp_udf)
    );

    qthr_level #(
        .MODE    (THR_FREE_SLOTS),
        .DEPTH   (CMD_DEPTH),
        .THR_W   (THR_W),
        .THR_MAX (CMD_THR_MAX)
    ) u_cmd_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cmd_thr_we),
        .wdata (thr_wdata),
        .count (cmd_count),
        .thr_q (cmd_thr),
        .irq   (cmd_ready_irq)
    );

    qthr_level #(
        .MODE    (THR_FILL_PLUS_ONE),
        .DEPTH   (RSP_DEPTH),
        .THR_W   (THR_W),
        .THR_MAX (RSP_THR_MAX)
    ) u_rsp_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rsp_thr_we),
        .wdata (thr_wdata),
        .count (rsp_count),
        .thr_q (rsp_thr),
        .irq   (rsp_ready_irq)
    );

    AST_EMPTY_CMD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_count == '0) |-> cmd_ready_irq);                          // R8
    AST_FULL_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_count == RSP_CNT_W'(RSP_DEPTH)) |-> rsp_ready_irq);       // R6
    AST_FULL_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_count == CMD_CNT_W'(CMD_DEPTH)) |-> !cmd_ready_irq);      // R8

endmodule

// File: tb/qthr_irq_top_bench.sv
// Bench for qthr_irq_top: directed corners followed by seeded random traffic,
// all compared against a behavioural queue and threshold model.
module qthr_irq_top_bench;

    localparam int DW = 32;
    localparam int CD = 16;
    localparam int RD = 8;
    localparam int TW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          cmd_push, cmd_pop, rsp_push, rsp_pop;
    logic [DW-1:0] cmd_wdata, rsp_wdata, cmd_rdata, rsp_rdata;
    logic [4:0]    cmd_count;
    logic [3:0]    rsp_count;
    logic          cmd_ovf, cmd_udf, rsp_ovf, rsp_udf;
    logic          thr_wr, thr_sel;
    logic [TW-1:0] thr_wdata, cmd_thr, rsp_thr;
    logic          cmd_ready_irq, rsp_ready_irq;

    qthr_irq_top u_qthr_irq_top (
        .clk(clk), .rst_n(rst_n),
        .cmd_push(cmd_push), .cmd_wdata(cmd_wdata), .cmd_pop(cmd_pop),
        .cmd_rdata(cmd_rdata), .cmd_count(cmd_count),
        .cmd_ovf(cmd_ovf), .cmd_udf(cmd_udf),
        .rsp_push(rsp_push), .rsp_wdata(rsp_wdata), .rsp_pop(rsp_pop),
        .rsp_rdata(rsp_rdata), .rsp_count(rsp_count),
        .rsp_ovf(rsp_ovf), .rsp_udf(rsp_udf),
        .thr_wr(thr_wr), .thr_sel(thr_sel), .thr_wdata(thr_wdata),
        .cmd_thr(cmd_thr), .rsp_thr(rsp_thr),
        .cmd_ready_irq(cmd_ready_irq), .rsp_ready_irq(rsp_ready_irq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Model state.
    logic [DW-1:0] mc [CD];
    logic [DW-1:0] mr [RD];
    int mc_h, mc_n, mr_h, mr_n;
    int m_cthr, m_rthr;
    bit m_covf, m_cudf, m_rovf, m_rudf;

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_cmd_irq(int n, int thr);
        if (thr == 0) return (n == 0);
        return ((CD - n) >= thr);
    endfunction

    function automatic bit exp_rsp_irq(int n, int thr);
        return (n >= thr + 1);
    endfunction

    function automatic int clamp(int v, int mx);
        return (v > mx) ? mx : v;
    endfunction

    task automatic model_reset();
        mc_h = 0; mc_n = 0; mr_h = 0; mr_n = 0;
        m_cthr = 1; m_rthr = 1;
        m_covf = 0; m_cudf = 0; m_rovf = 0; m_rudf = 0;
    endtask

    task automatic check_all();
        chk("R2", "cmd_count", cmd_count, mc_n);
        if (mc_n > 0) chk("R2", "cmd_rdata", cmd_rdata, mc[mc_h]);
        chk("R3", "rsp_count", rsp_count, mr_n);
        if (mr_n > 0) chk("R3", "rsp_rdata", rsp_rdata, mr[mr_h]);
        chk("R4", "cmd_ovf", cmd_ovf, m_covf);
        chk("R4", "cmd_udf", cmd_udf, m_cudf);
        chk("R4", "rsp_ovf", rsp_ovf, m_rovf);
        chk("R4", "rsp_udf", rsp_udf, m_rudf);
        chk("R9", "cmd_thr", cmd_thr, m_cthr);
        chk("R9", "rsp_thr", rsp_thr, m_rthr);
        chk(m_cthr == 0 ? "R7" : "R8", "cmd_ready_irq", cmd_ready_irq,
            exp_cmd_irq(mc_n, m_cthr));
        chk("R6", "rsp_ready_irq", rsp_ready_irq, exp_rsp_irq(mr_n, m_rthr));
    endtask

    // One cycle: drive at the falling edge, update the model after the
    // rising edge, check at the next falling edge.
    task automatic step(input bit cp, input logic [DW-1:0] cw, input bit cpp,
                        input bit rp, input logic [DW-1:0] rw, input bit rpp,
                        input bit we, input bit sel, input int wv);
        bit cfull, cemp, rfull, remp;
        cmd_push = cp; cmd_wdata = cw; cmd_pop = cpp;
        rsp_push = rp; rsp_wdata = rw; rsp_pop = rpp;
        thr_wr = we; thr_sel = sel; thr_wdata = TW'(wv);
        @(posedge clk);
        cfull = (mc_n == CD); cemp = (mc_n == 0);
        rfull = (mr_n == RD); remp = (mr_n == 0);
        if (cp) begin
            if (cfull) m_covf = 1; else mc[(mc_h + mc_n) % CD] = cw;
        end
        if (cpp) begin
            if (cemp) m_cudf = 1; else mc_h = (mc_h + 1) % CD;
        end
        mc_n = mc_n + ((cp && !cfull) ? 1 : 0) - ((cpp && !cemp) ? 1 : 0);
        if (rp) begin
            if (rfull) m_rovf = 1; else mr[(mr_h + mr_n) % RD] = rw;
        end
        if (rpp) begin
            if (remp) m_rudf = 1; else mr_h = (mr_h + 1) % RD;
        end
        mr_n = mr_n + ((rp && !rfull) ? 1 : 0) - ((rpp && !remp) ? 1 : 0);
        if (we) begin
            if (!sel) m_cthr = clamp(wv & 8'hFF, CD - 1);
            else      m_rthr = clamp(wv & 8'hFF, RD - 1);
        end
        @(negedge clk);
        cmd_push = 0; cmd_pop = 0; rsp_push = 0; rsp_pop = 0; thr_wr = 0;
        check_all();
    endtask

    task automatic cpush(input logic [DW-1:0] d); step(1, d, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic cpopt();                       step(0, 0, 1, 0, 0, 0, 0, 0, 0); endtask
    task automatic rpush(input logic [DW-1:0] d); step(0, 0, 0, 1, d, 0, 0, 0, 0); endtask
    task automatic rpopt();                       step(0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
    task automatic wthr(input bit sel, input int v); step(0, 0, 0, 0, 0, 0, 1, sel, v); endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0;
        cmd_push = 0; cmd_pop = 0; rsp_push = 0; rsp_pop = 0;
        cmd_wdata = 0; rsp_wdata = 0; thr_wr = 0; thr_sel = 0; thr_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state.
        chk("R1", "cmd_count", cmd_count, 0);
        chk("R1", "rsp_count", rsp_count, 0);
        chk("R1", "flags", {cmd_ovf, cmd_udf, rsp_ovf, rsp_udf}, 0);
        chk("R1", "cmd_thr", cmd_thr, 1);
        chk("R1", "rsp_thr", rsp_thr, 1);
        chk("R1", "cmd_ready_irq", cmd_ready_irq, 1);
        chk("R1", "rsp_ready_irq", rsp_ready_irq, 0);

        // R5: push and pop together on an empty command queue.
        step(1, 32'hA5A5_0001, 1, 0, 0, 0, 0, 0, 0);
        chk("R5", "cmd_count after push+pop on empty", cmd_count, 1);
        chk("R5", "cmd_udf after push+pop on empty", cmd_udf, 1);
        cpopt();

        // R2/R8: fill the command queue, irq drops once fewer than 1 free.
        for (int i = 0; i < CD; i++) cpush(32'hC000_0000 + i);
        chk("R8", "cmd_ready_irq when full", cmd_ready_irq, 0);
        // R4: push to full is discarded.
        cpush(32'hDEAD_BEEF);
        chk("R4", "cmd_count after overflow push", cmd_count, CD);
        chk("R4", "cmd_ovf", cmd_ovf, 1);
        chk("R4", "cmd head unchanged", cmd_rdata, 32'hC000_0000);
        // R5: push and pop together on a full queue.
        step(1, 32'h1234_5678, 1, 0, 0, 0, 0, 0, 0);
        chk("R5", "cmd_count after push+pop on full", cmd_count, CD - 1);

        // R7: threshold 0 needs a completely empty queue.
        wthr(0, 0);
        for (int i = 0; i < CD; i++) cpopt();
        chk("R7", "cmd_ready_irq empty thr0", cmd_ready_irq, 1);

        // R9: clamping on out-of-range writes.
        wthr(0, 200);
        chk("R9", "cmd_thr clamp", cmd_thr, 15);
        wthr(1, 9);
        chk("R9", "rsp_thr clamp", rsp_thr, 7);

        // R3/R6: response queue fills; irq only with all 8 present.
        for (int i = 0; i < RD; i++) rpush(32'hB000_0000 + i);
        chk("R6", "rsp_ready_irq at 8 with thr 7", rsp_ready_irq, 1);
        rpush(32'hFFFF_FFFF);
        chk("R4", "rsp_ovf", rsp_ovf, 1);
        rpopt();
        chk("R6", "rsp_ready_irq drops at 7", rsp_ready_irq, 0);
        for (int i = 0; i < RD; i++) rpopt();
        chk("R4", "rsp_udf", rsp_udf, 1);

        // Seeded random traffic over shifting fill biases and thresholds.
        for (int ph = 0; ph < 12; ph++) begin
            int bias;
            bias = (ph % 3 == 0) ? 80 : ((ph % 3 == 1) ? 20 : 50);
            for (int c = 0; c < 300; c++) begin
                bit cp, cpp, rp, rpp, we;
                cp  = ($urandom_range(99) < bias);
                cpp = ($urandom_range(99) >= bias);
                rp  = ($urandom_range(99) < bias);
                rpp = ($urandom_range(99) >= bias);
                we  = ($urandom_range(99) < 6);
                step(cp, $urandom, cpp, rp, $urandom, rpp, we,
                     bit'($urandom_range(1)), int'($urandom_range(20)));
            end
        end

        finish_run();
    end

endmodule